// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps the completion status of transmitted frames until the host reads it. Each time the transmitter finishes or gives up on a frame, one status byte enters a first-in, first-out queue. The byte packs a done marker, an echo of the frame's interrupt request, and the error causes. The host reads the oldest entry through a byte-wide register. It removes that entry by writing any value to the same register, so the write data is never used.

The block also holds the transmitter's enable state. A frame that ends on the collision limit turns the transmitter off, and so does a completion that finds the queue full. It stays off until the host sends an enable command. While the transmitter is off, completion events are ignored. A transmit-reset input empties the queue and turns the transmitter back on. A transmit-complete output stays high while any status is waiting.

Top module: `tx_status_queue`

## Requirements
- R1: After reset the queue is empty, `tx_complete` is low and `tx_enabled` is high. A host read in this state returns 0x00.
- R2: A pushed status byte is laid out as follows. Bit 7 is always 1. Bit 6 is the frame's interrupt request. Bit 5 is jabber, bit 4 is underrun, bit 3 is collision limit and bit 1 is reclaim error. Bits 2 and 0 are 0. A clean frame with no interrupt request therefore reads 0x80, and 0xC0 with the request.
- R3: Entries are read out in the order they were pushed, oldest first.
- R4: A host read strobe loads `rd_data` at the clock edge where the strobe is sampled. It loads the oldest entry, or 0x00 if the queue is empty. A read alone does not remove the entry.
- R5: A host write removes the oldest entry whatever value `host_wdata` carries. A write to an empty queue has no effect.
- R6: `tx_complete` is high exactly when the queue holds at least one entry.
- R7: The queue holds DEPTH entries (32 by default). DEPTH writes always empty a full queue. A push and a pop in the same cycle on a full queue are both accepted.
- R8: A push while the queue is full and not popped in that cycle is dropped. Bit 2 (overflow) is then set in the newest stored entry, and the transmitter is disabled.
- R9: Accepting an entry with the collision-limit flag disables the transmitter. While it is disabled, completion events are dropped. `tx_en_cmd` re-enables it. A disable in the same cycle as `tx_en_cmd` wins.
- R10: `tx_reset` empties the queue and re-enables the transmitter.
- R11: A push and a pop in the same cycle on a non-empty queue leave the entry count unchanged. The oldest entry goes and the new one is appended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Frame completion event |
| ev_ireq | input | 1 | Frame requested an interrupt |
| ev_reclaim | input | 1 | Reclaim error |
| ev_maxcoll | input | 1 | Collision limit reached |
| ev_underrun | input | 1 | Data underrun |
| ev_jabber | input | 1 | Jabber |
| host_rd | input | 1 | Host read strobe for the status register |
| host_wr | input | 1 | Host write strobe (pops the oldest entry) |
| host_wdata | input | 8 | Host write data, ignored |
| tx_en_cmd | input | 1 | Transmit-enable command |
| tx_reset | input | 1 | Transmit reset: flush queue, re-enable |
| rd_data | output | 8 | Registered status byte returned by a read |
| tx_complete | output | 1 | High while any status is queued |
| tx_enabled | output | 1 | Transmitter enable state |

## Verification
The bench builds the block with DEPTH = 32. This size makes it practical to fill the queue completely, so the full and overflow cases are exercised directly. The bench checks a simultaneous push and pop on a full queue. It then checks that the 33rd completion is dropped and marks the newest stored byte with the overflow bit. Draining with exactly 32 writes shows that the marked byte comes out last. Smaller vectors cover the byte layout, read-without-pop, and the enable latch with its disable-wins tie.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int BIT_DONE = 7;
  localparam int BIT_IREQ = 6;
  localparam int BIT_JAB  = 5;
  localparam int BIT_UNDR = 4;
  localparam int BIT_MAXC = 3;
  localparam int BIT_OVFL = 2;
  localparam int BIT_RECL = 1;
  localparam int STAT_W   = 8;

  typedef struct packed {
    logic ireq;
    logic reclaim;
    logic maxcoll;
    logic underrun;
    logic jabber;
  } txs_evt_t;
endpackage

// File: rtl/tx_status_encode.sv
module tx_status_encode
  import txs_pkg::*;
(
  input  txs_evt_t          evt,
  output logic [STAT_W-1:0] stat_byte,
  output logic              fatal
);
  always_comb begin
    stat_byte           = '0;
    stat_byte[BIT_DONE] = 1'b1;
    stat_byte[BIT_IREQ] = evt.ireq;
    stat_byte[BIT_JAB]  = evt.jabber;
    stat_byte[BIT_UNDR] = evt.underrun;
    stat_byte[BIT_MAXC] = evt.maxcoll;
    stat_byte[BIT_RECL] = evt.reclaim;
    fatal               = evt.maxcoll;
  end
endmodule

// File: rtl/tx_status_fifo.sv
module tx_status_fifo
  import txs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data,
  output logic         nonempty,
  output logic         ovf_hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, prev_ptr;
  logic [CW-1:0] count;
  logic [W-1:0]  newest_q;
  logic          full, do_push, do_pop, wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_byte;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == FULL_CNT);
  assign do_pop   = pop && (count != '0);
  assign do_push  = push && (!full || do_pop);
  assign ovf_hit  = push && full && !do_pop;
  assign prev_ptr = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;

  // one write port: either a new entry or the overflow mark on the newest one
  always_comb begin
    wr_en   = !flush && (do_push || ovf_hit);
    wr_addr = ovf_hit ? prev_ptr : wr_ptr;
    wr_byte = push_data;
    if (ovf_hit) begin
      wr_byte           = newest_q;
      wr_byte[BIT_OVFL] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
  end

  assign top_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      nonempty <= 1'b0;
      newest_q <= '0;
    end else begin
      if (do_push) wr_ptr <= inc(wr_ptr);
      if (do_pop)  rd_ptr <= inc(rd_ptr);
      if (wr_en)   newest_q <= wr_byte;
      case ({do_push, do_pop})
        2'b10: begin count <= count + 1'b1; nonempty <= 1'b1; end
        2'b01: begin count <= count - 1'b1; nonempty <= (count != CW'(1)); end
        default: ;
      endcase
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (count == FULL_CNT));
  a_r5_pop_one: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count != '0 && !flush) |=> (count == $past(count) - 1'b1));
  a_r11_push_pop_same: assert property (@(posedge clk) disable iff (rst)
    (pop && push && count != '0 && !flush) |=> (count == $past(count)));
  a_r6_nonempty_flag: assert property (@(posedge clk) disable iff (rst)
    nonempty == (count != '0));
endmodule

// File: rtl/tx_enable_latch.sv
module tx_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable_cmd,
  input  logic disable_evt,
  output logic enabled_q
);
  always_ff @(posedge clk) begin
    if (rst || clear)     enabled_q <= 1'b1;
    else if (disable_evt) enabled_q <= 1'b0;
    else if (enable_cmd)  enabled_q <= 1'b1;
  end

  a_r9_disable_wins: assert property (@(posedge clk) disable iff (rst)
    (disable_evt && !clear) |=> !enabled_q);
  a_r9_enable_cmd: assert property (@(posedge clk) disable iff (rst)
    (enable_cmd && !disable_evt) |=> enabled_q);
endmodule

// File: rtl/tx_status_queue.sv
module tx_status_queue
  import txs_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  input  logic        ev_ireq,
  input  logic        ev_reclaim,
  input  logic        ev_maxcoll,
  input  logic        ev_underrun,
  input  logic        ev_jabber,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        tx_en_cmd,
  input  logic        tx_reset,
  output logic [7:0]  rd_data,
  output logic        tx_complete,
  output logic        tx_enabled
);
  txs_evt_t          evt;
  logic [STAT_W-1:0] enc_byte, top_byte;
  logic              enc_fatal, accept, ovf_hit, nonempty, disable_evt;
  logic              wdata_unused;

  assign evt          = '{ireq: ev_ireq, reclaim: ev_reclaim, maxcoll: ev_maxcoll,
                          underrun: ev_underrun, jabber: ev_jabber};
  assign wdata_unused = ^host_wdata;
  assign accept       = ev_valid && tx_enabled;
  assign disable_evt  = accept && (enc_fatal || ovf_hit);

  tx_status_encode u_enc (
    .evt       (evt),
    .stat_byte (enc_byte),
    .fatal     (enc_fatal)
  );

  tx_status_fifo #(.DEPTH(DEPTH), .W(STAT_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (tx_reset),
    .push      (accept),
    .push_data (enc_byte),
    .pop       (host_wr),
    .top_data  (top_byte),
    .nonempty  (nonempty),
    .ovf_hit   (ovf_hit)
  );

  tx_enable_latch u_en (
    .clk         (clk),
    .rst         (rst),
    .clear       (tx_reset),
    .enable_cmd  (tx_en_cmd),
    .disable_evt (disable_evt),
    .enabled_q   (tx_enabled)
  );

  always_ff @(posedge clk) begin
    if (rst || tx_reset) rd_data <= '0;
    else if (host_rd)    rd_data <= nonempty ? top_byte : '0;
  end

  assign tx_complete = nonempty;

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !tx_complete && !tx_reset) |=> (rd_data == 8'h00));
  a_r9_disabled_drop: assert property (@(posedge clk) disable iff (rst)
    (!tx_enabled && ev_valid && !host_wr && !tx_reset) |=> $stable(tx_complete));
  a_r10_flush: assert property (@(posedge clk) disable iff (rst)
    tx_reset |=> (!tx_complete && tx_enabled));
  a_r2_done_bit: assert property (@(posedge clk) disable iff (rst)
    (host_rd && tx_complete && !tx_reset) |=> rd_data[BIT_DONE]);
endmodule

// File: tb/tx_status_queue_bench.sv
module tx_status_queue_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 0, ev_ireq = 0, ev_reclaim = 0, ev_maxcoll = 0;
  logic       ev_underrun = 0, ev_jabber = 0;
  logic       host_rd = 0, host_wr = 0, tx_en_cmd = 0, tx_reset = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] rd_data;
  logic       tx_complete, tx_enabled;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_status_queue #(.DEPTH(32)) u_tx_status_queue (
    .clk, .rst, .ev_valid, .ev_ireq, .ev_reclaim, .ev_maxcoll, .ev_underrun,
    .ev_jabber, .host_rd, .host_wr, .host_wdata, .tx_en_cmd, .tx_reset,
    .rd_data, .tx_complete, .tx_enabled
  );

  // row: ev, flags{ir,rc,mc,ur,jb}, rd, wr, en, exp_cmp, exp_en, chk_rd, exp_rd
  function automatic logic [19:0] mk(input logic ev, input logic [4:0] fl,
      input logic rd, input logic wr, input logic en, input logic c,
      input logic e, input logic k, input logic [7:0] x);
    return {ev, fl, rd, wr, en, c, e, k, x};
  endfunction

  localparam int NV = 21;
  localparam logic [19:0] TBL [NV] = '{
    mk(0,5'b00000,1,0,0, 0,1,1,8'h00),  // R1 empty read
    mk(1,5'b00000,0,0,0, 1,1,0,8'h00),  // R2 clean frame
    mk(1,5'b10010,0,0,0, 1,1,0,8'h00),  // R2 ireq+underrun
    mk(1,5'b01001,0,0,0, 1,1,0,8'h00),  // R2 jabber+reclaim
    mk(0,5'b00000,1,0,0, 1,1,1,8'h80),  // R3 oldest first
    mk(0,5'b00000,0,1,0, 1,1,0,8'h00),  // R5 pop
    mk(0,5'b00000,1,0,0, 1,1,1,8'hD0),  // R4 read
    mk(0,5'b00000,1,1,0, 1,1,1,8'hD0),  // R4 read then pop
    mk(0,5'b00000,1,0,0, 1,1,1,8'hA2),  // R3
    mk(1,5'b00100,0,1,0, 1,0,0,8'h00),  // R11 push+pop, R9 disable
    mk(1,5'b00000,1,0,0, 1,0,1,8'h88),  // R9 event dropped
    mk(0,5'b00000,0,1,0, 0,0,0,8'h00),  // R6 empty
    mk(0,5'b00000,1,0,0, 0,0,1,8'h00),  // R9 nothing entered
    mk(0,5'b00000,0,0,1, 0,1,0,8'h00),  // R9 enable cmd
    mk(1,5'b10000,0,0,0, 1,1,0,8'h00),  // R2 ireq only
    mk(0,5'b00000,1,1,0, 0,1,1,8'hC0),  // R5 pop
    mk(0,5'b00000,0,1,0, 0,1,0,8'h00),  // R5 pop empty
    mk(0,5'b00000,1,0,0, 0,1,1,8'h00),  // R4 empty
    mk(1,5'b00100,0,0,1, 1,0,0,8'h00),  // R9 disable wins
    mk(0,5'b00000,0,1,0, 0,0,0,8'h00),
    mk(0,5'b00000,0,0,1, 0,1,0,8'h00)
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ev, input logic [4:0] fl, input logic rd,
      input logic wr, input logic [7:0] wd, input logic en, input logic trst);
    @(negedge clk);
    ev_valid = ev; {ev_ireq, ev_reclaim, ev_maxcoll, ev_underrun, ev_jabber} = fl;
    host_rd = rd; host_wr = wr; host_wdata = wd; tx_en_cmd = en; tx_reset = trst;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1;
    check("R1 complete", tx_complete, 0);
    check("R1 enabled", tx_enabled, 1);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = TBL[i];
      step(v[19], v[18:14], v[13], v[12], 8'(i * 37), v[11], 0);
      check($sformatf("R6 row %0d complete", i), tx_complete, v[10]);
      check($sformatf("R9 row %0d enabled", i), tx_enabled, v[9]);
      if (v[8]) check($sformatf("R4 row %0d rd_data", i), rd_data, v[7:0]);
    end

    // fill to capacity: entry k has ireq = k[0]
    for (int k = 0; k < 32; k++) step(1, {k[0], 4'b0000}, 0, 0, 0, 0, 0);
    check("R7 full complete", tx_complete, 1);
    check("R7 full enabled", tx_enabled, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    check("R3 full top", rd_data, 8'h80);
    // push+pop while full: accepted
    step(1, 5'b00000, 0, 1, 8'hFF, 0, 0);
    check("R7 push+pop full enabled", tx_enabled, 1);
    // overflow push
    step(1, 5'b10000, 0, 0, 0, 0, 0);
    check("R8 overflow disables", tx_enabled, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    check("R8 top unchanged", rd_data, 8'hC0);
    for (int k = 0; k < 31; k++) step(0, 0, 0, 1, 8'(k), 0, 0);
    check("R7 one left", tx_complete, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    check("R8 newest marked", rd_data, 8'h84);
    step(0, 0, 0, 1, 8'h5A, 0, 0);
    check("R7 drained by DEPTH writes", tx_complete, 0);

    // transmit reset
    step(0, 0, 0, 0, 0, 1, 0);
    step(1, 5'b00100, 0, 0, 0, 0, 0);
    step(1, 5'b00000, 0, 0, 0, 0, 0);
    check("R9 dropped while disabled", tx_complete, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    check("R10 flushed", tx_complete, 0);
    check("R10 re-enabled", tx_enabled, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    check("R10 empty read", rd_data, 8'h00);
    step(1, 5'b00001, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    check("R2 jabber byte", rd_data, 8'hA0);

    finish_run();
  end
endmodule